// File: doc/BRIEF.md
# Key-Sequence Access Gate

This block guards a protected information region behind a write-only control register. Software opens the region by writing three fixed 32-bit key words to the register, in a fixed order. After the last key is accepted, the block raises a grant signal. The grant lets reads and writes reach both the system and the user parts of the region. While access is granted, any further write to the register closes the region again, whatever value is written.

Region accesses are presented as single-cycle request strobes. While the gate is open, a request passes straight through as an allow in the same cycle. While the gate is closed, the request is blocked, and a one-cycle denied pulse follows on the next clock. The register never exposes its state: its read data is always zero.

The key words, the number of keys and the data width are parameters. Each key is compared once in a generated comparator bank. A small step counter tracks how far into the sequence the writes have reached.

Top module: `akey_unlock`

## Requirements
- R1: After reset the gate is closed (`granted_o` = 0) and the sequence is at its start, so a full three-key sequence is needed to open it.
- R2: Writing 0x3a7f5ca3, then 0xa1e34f20, then 0x9608b2c1 with no other register write between them sets `granted_o` on the clock edge that takes the third write. It is therefore visible in the cycle after that write.
- R3: While closed, a write that does not match the key expected next, and is not equal to the first key, returns the sequence to its start.
- R4: While closed, a write equal to the first key (0x3a7f5ca3) that is not the expected key leaves the sequence at step one. Only the second and third keys are then needed to open the gate.
- R5: While granted, any register write, including any key value, clears `granted_o` on that clock edge.
- R6: A relocking write does not count as a sequence word. After relocking, the full three-key sequence is needed again.
- R7: `reg_rdata_o` is zero at all times, whatever was written.
- R8: While granted, `region_allow_o` equals `region_req_i` in the same cycle. This allows accesses to both the system and the user information areas.
- R9: While closed, `region_allow_o` stays low. Each cycle with `region_req_i` high gives exactly one cycle of `region_deny_o` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe, one write per high cycle |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, always zero |
| region_req_i | input | 1 | Region access attempt strobe (read or write) |
| region_allow_o | output | 1 | Access is let through this cycle |
| region_deny_o | output | 1 | One-cycle pulse: the previous cycle's attempt was blocked |
| granted_o | output | 1 | Region is open |

## Verification
The grant is registered, so a key or relock write driven in one cycle shows its effect on `granted_o` in the next cycle. The bench drives each write on a falling edge and compares on the following falling edge against its own sequence model. `region_allow_o` is combinational, so it is compared one time unit after the request is driven, against the model's grant from before the edge. `region_deny_o` is due one cycle after a blocked request, and it is compared on the same falling edge as the grant. It is compared against the grant state the model held when the request was made. Directed sequences cover R1 to R9; a seeded random mix of keys, near-keys and region requests then exercises every transition.

// File: rtl/akey_pkg.sv
package akey_pkg;

   // Convert a key count into the width of a step counter that indexes it.
   function automatic int step_width(input int n_keys);
      return (n_keys <= 2) ? 1 : $clog2(n_keys);
   endfunction

endpackage

// File: rtl/akey_match.sv
// Bank of key comparators: one equality test per key word.
module akey_match #(
   parameter int DATA_W   = 32,
   parameter int NUM_KEYS = 3,
   parameter logic [NUM_KEYS-1:0][DATA_W-1:0] KEYS = '0
) (
   input  logic [DATA_W-1:0]   wdata_i,
   output logic [NUM_KEYS-1:0] hit_o
);

   initial begin
      if (NUM_KEYS < 2) $error("akey_match: NUM_KEYS must be at least 2");
   end

   for (genvar g = 0; g < NUM_KEYS; g++) begin : g_cmp
      assign hit_o[g] = (wdata_i == KEYS[g]);
   end

endmodule

// File: rtl/akey_seq.sv
// Sequence tracker: step counter plus grant flag.
module akey_seq #(
   parameter int NUM_KEYS = 3,
   parameter int STEP_W   = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [NUM_KEYS-1:0] hit_i,
   output logic                granted_o,
   output logic [STEP_W-1:0]   step_o
);

   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_KEYS - 1);
   localparam logic [STEP_W-1:0] ONE_STEP  = STEP_W'(1);

   initial begin
      if ((1 << STEP_W) < NUM_KEYS) $error("akey_seq: STEP_W too small");
   end

   logic [STEP_W-1:0] step_q;
   logic              granted_q;
   logic              hit_cur;

   // Select the comparator that belongs to the current step.
   always_comb begin
      hit_cur = 1'b0;
      for (int i = 0; i < NUM_KEYS; i++) begin
         if (step_q == STEP_W'(i)) hit_cur = hit_i[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q    <= '0;
         granted_q <= 1'b0;
      end else if (wr_i) begin
         if (granted_q) begin
            granted_q <= 1'b0;
            step_q    <= '0;
         end else if (hit_cur) begin
            if (step_q == LAST_STEP) begin
               granted_q <= 1'b1;
               step_q    <= '0;
            end else begin
               step_q <= step_q + ONE_STEP;
            end
         end else if (hit_i[0]) begin
            step_q <= ONE_STEP;
         end else begin
            step_q <= '0;
         end
      end
   end

   assign granted_o = granted_q;
   assign step_o    = step_q;

   p_grant_needs_last_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(granted_q) |-> $past(wr_i && hit_i[NUM_KEYS-1]));

   p_wrong_word_restarts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !granted_q && !hit_cur && !hit_i[0]) |=> (step_q == '0 && !granted_q));

   p_first_key_step_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !granted_q && !hit_cur && hit_i[0]) |=> (step_q == ONE_STEP));

   p_write_relocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && granted_q) |=> (!granted_q && step_q == '0));

   p_step_in_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      step_q <= LAST_STEP);

endmodule

// File: rtl/akey_gate.sv
// Region gate: passes requests when granted, pulses deny otherwise.
module akey_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic granted_i,
   input  logic req_i,
   output logic allow_o,
   output logic deny_o
);

   logic deny_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) deny_q <= 1'b0;
      else        deny_q <= req_i & ~granted_i;
   end

   assign allow_o = req_i & granted_i;
   assign deny_o  = deny_q;

   p_deny_follows_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
      deny_q |-> $past(req_i && !granted_i));

   p_blocked_gets_deny_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_i && !granted_i) |=> deny_q);

endmodule

// File: rtl/akey_unlock.sv
// Top: write-only key register guarding an information region.
module akey_unlock #(
   parameter int DATA_W   = 32,
   parameter int NUM_KEYS = 3,
   parameter logic [NUM_KEYS-1:0][DATA_W-1:0] KEYS =
      {32'h9608b2c1, 32'ha1e34f20, 32'h3a7f5ca3}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              region_req_i,
   output logic              region_allow_o,
   output logic              region_deny_o,
   output logic              granted_o
);

   localparam int STEP_W = akey_pkg::step_width(NUM_KEYS);

   initial begin
      if (DATA_W < 1)   $error("akey_unlock: DATA_W must be positive");
      if (NUM_KEYS < 2) $error("akey_unlock: NUM_KEYS must be at least 2");
   end

   logic [NUM_KEYS-1:0] hit;
   logic [STEP_W-1:0]   step;
   logic                granted;

   akey_match #(.DATA_W(DATA_W), .NUM_KEYS(NUM_KEYS), .KEYS(KEYS)) u_match (
      .wdata_i (reg_wdata_i),
      .hit_o   (hit)
   );

   akey_seq #(.NUM_KEYS(NUM_KEYS), .STEP_W(STEP_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (reg_wr_i),
      .hit_i     (hit),
      .granted_o (granted),
      .step_o    (step)
   );

   akey_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .granted_i (granted),
      .req_i     (region_req_i),
      .allow_o   (region_allow_o),
      .deny_o    (region_deny_o)
   );

   assign reg_rdata_o = '0;
   assign granted_o   = granted;

   p_allow_only_granted_r8: assert property (@(posedge clk) disable iff (!rst_n)
      region_allow_o |-> (granted_o && step == '0));

endmodule

// File: tb/tb_akey_unlock.sv
module tb_akey_unlock;

   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] K0 = 32'h3a7f5ca3;
   localparam logic [31:0] K1 = 32'ha1e34f20;
   localparam logic [31:0] K2 = 32'h9608b2c1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_i = 1'b0;
   logic [31:0] reg_wdata_i = '0;
   logic [31:0] reg_rdata_o;
   logic        region_req_i = 1'b0;
   logic        region_allow_o;
   logic        region_deny_o;
   logic        granted_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit finished = 0;

   // reference model state
   int m_step    = 0;
   bit m_granted = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   akey_unlock dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .region_req_i(region_req_i),
      .region_allow_o(region_allow_o), .region_deny_o(region_deny_o),
      .granted_o(granted_o)
   );

   function automatic logic [31:0] key_at(input int s);
      return (s == 0) ? K0 : (s == 1) ? K1 : K2;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
      end
   endtask

   // Model update for one register write.
   task automatic model_write(input logic [31:0] d);
      if (m_granted) begin
         m_granted = 0; m_step = 0;
      end else if (d == key_at(m_step)) begin
         if (m_step == 2) begin m_granted = 1; m_step = 0; end
         else m_step = m_step + 1;
      end else if (d == K0) m_step = 1;
      else m_step = 0;
   endtask

   // One cycle: drive at falling edge, check comb outputs, clock, check registered outputs.
   task automatic cyc(input bit wr, input logic [31:0] d, input bit req, input string tag);
      bit exp_deny;
      reg_wr_i = wr; reg_wdata_i = d; region_req_i = req;
      #1;
      check({tag, " R8 allow"}, {31'b0, region_allow_o}, {31'b0, req && m_granted});
      check({tag, " R7 rdata"}, reg_rdata_o, 32'h0);
      @(posedge clk);
      exp_deny = req && !m_granted;
      if (wr) model_write(d);
      @(negedge clk);
      check({tag, " R2 granted"}, {31'b0, granted_o}, {31'b0, m_granted});
      check({tag, " R9 deny"}, {31'b0, region_deny_o}, {31'b0, exp_deny});
      reg_wr_i = 1'b0; region_req_i = 1'b0;
   endtask

   task automatic idle(input string tag);
      cyc(1'b0, 32'h0, 1'b0, tag);
   endtask

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      check("R1 reset granted", {31'b0, granted_o}, 32'h0);
      check("R1 reset deny", {31'b0, region_deny_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: two later keys alone must not open
      cyc(1, K1, 0, "R1 k1 only"); cyc(1, K2, 0, "R1 k2 only");
      check("R1 still closed", {31'b0, granted_o}, 32'h0);

      // R9: blocked access, then idle to see single pulse
      cyc(0, 0, 1, "R9 blocked"); idle("R9 pulse end");
      check("R9 deny one cycle", {31'b0, region_deny_o}, 32'h0);

      // R2: correct sequence
      cyc(1, K0, 0, "R2 k0"); cyc(1, K1, 0, "R2 k1");
      check("R2 not yet", {31'b0, granted_o}, 32'h0);
      cyc(1, K2, 0, "R2 k2");
      check("R2 open", {31'b0, granted_o}, 32'h1);
      cyc(0, 0, 1, "R8 allowed access"); idle("R8 no deny");

      // R5: relock with a key value; R6: relock write not counted
      cyc(1, K0, 0, "R5 relock");
      check("R5 closed", {31'b0, granted_o}, 32'h0);
      cyc(1, K1, 0, "R6 k1"); cyc(1, K2, 0, "R6 k2");
      check("R6 still closed", {31'b0, granted_o}, 32'h0);

      // R3: wrong middle word restarts
      cyc(1, K0, 0, "R3 k0"); cyc(1, 32'h1234_5678, 0, "R3 bad");
      cyc(1, K1, 0, "R3 k1"); cyc(1, K2, 0, "R3 k2");
      check("R3 closed after restart", {31'b0, granted_o}, 32'h0);

      // R4: first key repeated leaves step one
      cyc(1, K0, 0, "R4 k0"); cyc(1, K0, 0, "R4 k0 again");
      cyc(1, K1, 0, "R4 k1"); cyc(1, K2, 0, "R4 k2");
      check("R4 opened", {31'b0, granted_o}, 32'h1);
      cyc(1, 32'hffff_ffff, 1, "R5 relock with access");

      // Random mix
      for (int i = 0; i < 2000; i++) begin
         int sel = $urandom_range(0, 9);
         logic [31:0] d;
         case (sel)
            0, 1, 2: d = K0;
            3, 4:    d = K1;
            5, 6:    d = K2;
            7:       d = K1 ^ (32'h1 << $urandom_range(0, 31));
            default: d = $urandom;
         endcase
         cyc($urandom_range(0, 3) != 0, d, $urandom_range(0, 1) == 1, "RND R3 R4 R5");
      end

      finished = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!finished) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule